// File: doc/BRIEF.md
# Serial Wiper Register Port with Release-Triggered Commands

This block is a serial mode-0 peripheral port that owns two 8-bit control registers: a tap-position register that steers a downstream wiper, and a mode register holding a shutdown-enable flag and an output-drive selector. The host sends 16-bit frames made of an opcode/address byte and a data byte. Frames are only captured while chip select is low. The decoded command runs when chip select is released, so a chain of these ports can be loaded in one frame and all of them update together.

A read does not answer in the frame that asks for it. When chip select rises, the answer is loaded into the shift path as a tagged word: the tag 111, the 5-bit address, then the data byte. The host collects it in the next frame while sending a no-op. Because the shift path is a plain 16-bit delay line, a frame longer than 16 bits passes its earlier bits out to the next device in the chain. The serial pins are sampled in the system clock domain through two-flop synchronizers, so the system clock must run at least 8 times faster than the serial clock. The data output can drive in push-pull style or in open-drain style, where an external pull-up supplies the high level.

Top module: `spi_tap_ctrl`

## Requirements
- R1: After reset the tap register reads 40h, the mode register reads 40h, and the data output is not driven.
- R2: Serial mode 0 is used. Input bits are captured on the rising serial clock edge and sent most significant bit first. The output bit changes after the falling edge, and the first output bit is valid after chip select falls.
- R3: The opcode is instruction bits 7:5 and the address is bits 4:0. Opcode 110 writes the addressed register and opcode 011 writes the mode register. Address 00000 is the tap register and address 10000 is the mode register.
- R4: While chip select is low, neither register changes. A decoded write takes effect only after chip select rises.
- R5: Opcode 100 reads the addressed register and opcode 001 reads the mode register. At chip select rise the shift path is loaded with {111, address, data}, and the next frame shifts this word out MSB first.
- R6: A tap write keeps only data bits 6:0, and the tap register reads back with bit 7 as 0. The mode register keeps only bit 6 (shutdown enable, 1 means normal) and bit 1 (1 means open-drain output). Its other bits read as 0.
- R7: Nothing executes for a frame shorter than 16 bits, for opcode 000 or any unlisted opcode, or for an address other than 00000 or 10000. An ignored frame leaves its own 16 bits in the shift path.
- R8: In a frame longer than 16 bits only the last 16 bits are decoded. Each input bit appears on the output 16 bit positions later.
- R9: The output enable is low while chip select is high. In open-drain mode the output never drives a high level.
- R10: After reset, no frame is accepted and the output is not driven until a high-to-low transition of chip select has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low chip select |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Output enable for the data out pad |
| wiper_pos | output | 7 | Current tap position |
| ctrl_reg | output | 8 | Current mode register |

## Verification
The hardest case to reach is the pass-through path. To see it, the host must hold chip select low past 16 bits. The bench then checks that the bits it sent first come out again, unchanged, in the tail of the same frame, and that only the trailing 16 bits act as the command. The second hard case is reset with chip select already held low. The bench releases reset in that state and clocks a full write frame, which must have no effect. The delayed answer to a read is checked across two frames, in both drive styles, with an external pull-up modelled on the output.

// File: rtl/spi_tap_ctrl.sv
module spi_tap_ctrl #(
  parameter int TAP_BITS = 7,
  parameter logic [TAP_BITS-1:0] WIPER_INIT = 7'h40,
  parameter logic [7:0] CTRL_INIT = 8'h40,
  parameter logic [7:0] CTRL_MASK = 8'h42,
  parameter int FRAME_BITS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck,
  input  logic                sdi,
  input  logic                cs_n,
  output logic                sdo_o,
  output logic                sdo_oe,
  output logic [TAP_BITS-1:0] wiper_pos,
  output logic [7:0]          ctrl_reg
);
  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam int MSB = FRAME_BITS - 1;
  localparam logic [4:0] ADDR_TAP = 5'h00;
  localparam logic [4:0] ADDR_MODE = 5'h10;

  logic [1:0] sck_m, sdi_m, cs_m;
  logic sck_d, cs_d;
  logic armed, sdo_bit;
  logic [CW-1:0] cnt;
  logic [MSB:0] shreg;

  wire sck_s = sck_m[1];
  wire sdi_s = sdi_m[1];
  wire cs_s  = cs_m[1];
  wire sck_rise = sck_s & ~sck_d;
  wire sck_fall = ~sck_s & sck_d;
  wire cs_fall  = ~cs_s & cs_d;
  wire cs_rise  = cs_s & ~cs_d;
  wire exec = cs_rise & armed & (cnt == CW'(FRAME_BITS));

  wire [2:0] op   = shreg[MSB -: 3];
  wire [4:0] addr = shreg[MSB-3 -: 5];
  wire [7:0] dat  = shreg[7:0];
  wire [7:0] tap_byte = {{(8-TAP_BITS){1'b0}}, wiper_pos};

  logic wr_tap, wr_mode, rd;
  logic [4:0] rd_addr;

  always_comb begin
    wr_tap = 1'b0;
    wr_mode = 1'b0;
    rd = 1'b0;
    rd_addr = addr;
    case (op)
      3'b001: begin rd = 1'b1; rd_addr = ADDR_MODE; end
      3'b011: wr_mode = 1'b1;
      3'b100: rd = (addr == ADDR_TAP) || (addr == ADDR_MODE);
      3'b110: begin
        wr_tap  = (addr == ADDR_TAP);
        wr_mode = (addr == ADDR_MODE);
      end
      default: ;
    endcase
  end

  wire [15:0] rd_word = {3'b111, rd_addr, (rd_addr == ADDR_MODE) ? ctrl_reg : tap_byte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m <= '0; sdi_m <= '0; cs_m <= '0;
      sck_d <= 1'b0; cs_d <= 1'b0;
    end else begin
      sck_m <= {sck_m[0], sck};
      sdi_m <= {sdi_m[0], sdi};
      cs_m  <= {cs_m[0], cs_n};
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt <= '0;
      shreg <= '0;
      sdo_bit <= 1'b0;
      wiper_pos <= WIPER_INIT;
      ctrl_reg <= CTRL_INIT;
    end else begin
      if (cs_fall) begin
        armed <= 1'b1;
        cnt <= '0;
        sdo_bit <= shreg[MSB];
      end else if (!cs_s && armed) begin
        if (sck_rise) begin
          shreg <= {shreg[MSB-1:0], sdi_s};
          if (cnt != CW'(FRAME_BITS)) cnt <= cnt + 1'b1;
        end
        if (sck_fall) sdo_bit <= shreg[MSB];
      end
      if (exec) begin
        if (wr_tap)  wiper_pos <= dat[TAP_BITS-1:0];
        if (wr_mode) ctrl_reg <= dat & CTRL_MASK;
        if (rd)      shreg <= rd_word;
      end
    end
  end

  wire od = ctrl_reg[1];
  wire active = armed & ~cs_s;
  assign sdo_oe = active & (od ? ~sdo_bit : 1'b1);
  assign sdo_o  = od ? 1'b0 : sdo_bit;
endmodule

// File: rtl/spi_tap_ctrl_chk.sv
module spi_tap_ctrl_chk #(
  parameter int TAP_BITS = 7,
  parameter logic [7:0] CTRL_MASK = 8'h42,
  parameter int FRAME_BITS = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cs_s,
  input logic                         armed,
  input logic                         exec,
  input logic [$clog2(FRAME_BITS+1)-1:0] cnt,
  input logic                         sdo_o,
  input logic                         sdo_oe,
  input logic [TAP_BITS-1:0]          wiper_pos,
  input logic [7:0]                   ctrl_reg
);
  AST_HIZ_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) cs_s |-> !sdo_oe); // R9
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_reg[1] && sdo_oe) |-> !sdo_o); // R9
  AST_HOLD_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n) !exec |=> ($stable(wiper_pos) && $stable(ctrl_reg))); // R4
  AST_MODE_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_reg & ~CTRL_MASK) == 8'h00); // R6
  AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !armed |-> !sdo_oe); // R10
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= ($clog2(FRAME_BITS+1))'(FRAME_BITS)); // R7
endmodule

bind spi_tap_ctrl spi_tap_ctrl_chk #(.TAP_BITS(TAP_BITS), .CTRL_MASK(CTRL_MASK), .FRAME_BITS(FRAME_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .armed(armed), .exec(exec), .cnt(cnt),
  .sdo_o(sdo_o), .sdo_oe(sdo_oe), .wiper_pos(wiper_pos), .ctrl_reg(ctrl_reg)
);

// File: tb/spi_tap_ctrl_test.sv
module spi_tap_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic cs_n = 1'b0;
  logic sdo_o, sdo_oe;
  logic [6:0] wiper_pos;
  logic [7:0] ctrl_reg;
  int total = 0;
  int bad = 0;
  logic od_high_seen = 1'b0;
  logic [31:0] got;

  spi_tap_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .cs_n(cs_n),
    .sdo_o(sdo_o), .sdo_oe(sdo_oe), .wiper_pos(wiper_pos), .ctrl_reg(ctrl_reg)
  );

  always #10 clk = ~clk;

  wire host_sdo = sdo_oe ? sdo_o : 1'b1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [31:0] w, input int n, output logic [31:0] rx);
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i];
      tick(8);
      rx = {rx[30:0], host_sdo};
      if (sdo_oe && sdo_o && ctrl_reg[1]) od_high_seen = 1'b1;
      sck = 1'b1;
      tick(8);
      sck = 1'b0;
    end
    tick(8);
  endtask

  task automatic cs_lo; cs_n = 1'b0; tick(8); endtask
  task automatic cs_hi; cs_n = 1'b1; tick(8); endtask

  task automatic xfer(input logic [31:0] w, input int n, output logic [31:0] rx);
    cs_lo();
    shift_bits(w, n, rx);
    cs_hi();
  endtask

  task automatic t_no_arm;
    logic [31:0] rx;
    chk("R10", "oe before first select edge", sdo_oe, 0);
    shift_bits(32'hC005, 16, rx);
    chk("R10", "oe during unarmed frame", sdo_oe, 0);
    cs_hi();
    chk("R10", "tap after unarmed frame", wiper_pos, 7'h40);
  endtask

  task automatic t_reset;
    chk("R1", "tap reset", wiper_pos, 7'h40);
    chk("R1", "mode reset", ctrl_reg, 8'h40);
    chk("R1", "oe reset", sdo_oe, 0);
  endtask

  task automatic t_write_deferred;
    logic [31:0] rx;
    cs_lo();
    shift_bits(32'hC025, 16, rx);
    chk("R4", "tap while select low", wiper_pos, 7'h40);
    cs_hi();
    chk("R3", "tap after release", wiper_pos, 7'h25);
  endtask

  task automatic t_tap_read;
    logic [31:0] rx;
    xfer(32'hC0FF, 16, rx);
    chk("R6", "tap bit7 dropped", wiper_pos, 7'h7F);
    xfer(32'h8000, 16, rx);
    xfer(32'h0000, 16, rx);
    chk("R5", "tap read word", rx[15:0], 16'hE07F);
    chk("R2", "tap read MSB first", rx[15], 1);
  endtask

  task automatic t_mode;
    logic [31:0] rx;
    xfer(32'h60FF, 16, rx);
    chk("R6", "mode masked", ctrl_reg, 8'h42);
    xfer(32'h2000, 16, rx);
    xfer(32'h0000, 16, rx);
    chk("R5", "mode read opcode 001 (open drain)", rx[15:0], 16'hF042);
    chk("R9", "open drain never drove high", od_high_seen, 0);
    xfer(32'hD040, 16, rx);
    chk("R3", "mode via addressed write", ctrl_reg, 8'h40);
    xfer(32'h9000, 16, rx);
    xfer(32'h0000, 16, rx);
    chk("R5", "mode read opcode 100", rx[15:0], 16'hF040);
  endtask

  task automatic t_ignored;
    logic [31:0] rx;
    xfer(32'hC0, 8, rx);
    chk("R7", "8-bit frame ignored", wiper_pos, 7'h7F);
    xfer(32'h6000, 15, rx);
    chk("R7", "15-bit frame ignored", ctrl_reg, 8'h40);
    xfer(32'hE011, 16, rx);
    chk("R7", "opcode 111 ignored", wiper_pos, 7'h7F);
    xfer(32'hC511, 16, rx);
    chk("R7", "bad address ignored", wiper_pos, 7'h7F);
    xfer(32'h0011, 16, rx);
    chk("R7", "nop no change", wiper_pos, 7'h7F);
    xfer(32'h8500, 16, rx);
    xfer(32'h0000, 16, rx);
    chk("R7", "bad-address read echoes frame", rx[15:0], 16'h8500);
  endtask

  task automatic t_long;
    logic [31:0] rx;
    xfer(32'hA5C011, 24, rx);
    chk("R8", "passthrough tail", rx[7:0], 8'hA5);
    chk("R8", "last 16 bits decoded", wiper_pos, 7'h11);
  endtask

  task automatic t_hiz;
    chk("R9", "oe with select high", sdo_oe, 0);
    cs_lo();
    chk("R9", "oe push-pull selected", sdo_oe, 1);
    cs_hi();
    chk("R9", "oe after release", sdo_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_no_arm();
    t_reset();
    t_write_deferred();
    t_tap_read();
    t_mode();
    t_ignored();
    t_long();
    t_hiz();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule